// File: doc/BRIEF.md
# DMA Channel Request Synchronizer

This block keeps the run state of a bank of DMA channels in step with hardware request lines. Each channel is configured with an enable, a request-line number and a synchronization granularity. Line number zero marks a free-running channel that runs as soon as it is enabled. A request pulse names one line. Every enabled channel tied to that line then either starts, records a single pending request, or, when one is already pending, flags a dropped event and asks for an interrupt update.

The transfer engine reports element, frame and packet boundaries for a channel. At a boundary that matches the channel's granularity, the block decides whether the channel stops. A pending request is used up to keep it running, unless the channel is waiting for end-of-programming. A request line that is still held high also keeps it running. Otherwise the channel goes idle. A global busy output tells the rest of the controller whether any channel is running.

Top module: `dma_req_sync`

## Requirements
- R1: After reset, every channel's active, pending and drop bits are 0, and irq_upd and busy are 0.
- R2: A request pulse whose nonzero line equals an enabled, inactive channel's line makes that channel active one cycle later.
- R3: A matching request for an active channel with no pending request sets its pending bit.
- R4: A matching request for an active channel that already has a pending request sets its drop bit and pulses irq_upd for one cycle.
- R5: A qualifying boundary on a channel with a pending request clears the pending bit and leaves the channel active, unless its wait bit is 1.
- R6: A qualifying boundary without a usable pending request leaves a synchronized channel active while bit `line` of drq is 1.
- R7: A qualifying boundary deactivates a synchronized channel in all other cases. A boundary qualifies when the channel is active and synchronized and bnd_ch names it. The granularity pair (frame-sync, block-sync) selects the boundary kind: 00 with kind 0 (element), 10 with kind 1 (frame), 11 with kind 2 (packet). The pair 01 matches no kind.
- R8: On the cycle after an enable rises, the channel is active if its line is 0 or its drq bit is 1, and inactive otherwise. Its pending bit is cleared.
- R9: On the cycle after an enable falls, the channel is inactive and its pending bit is cleared.
- R10: chan_sync[i] is 1 exactly when channel i is active and its line is nonzero.
- R11: busy is the OR of all channel active bits.
- R12: Request pulses on line 0 and requests to disabled channels change no state.
- R13: A drop bit stays set until drop_ack for that channel. A collision in the same cycle as the acknowledge leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chan_en | input | NCH | Per-channel enable |
| chan_line | input | NCH*LW | Per-channel request line number, channel i at bits i*LW |
| chan_gran | input | 2*NCH | Per-channel {frame-sync, block-sync} pair |
| chan_wait | input | NCH | Channel waits for end-of-programming |
| drq | input | NLINE | Request line levels |
| req_vld | input | 1 | Request pulse valid |
| req_line | input | LW | Line named by the request pulse |
| bnd_vld | input | 1 | Boundary report valid |
| bnd_ch | input | CW | Channel of the boundary |
| bnd_kind | input | 2 | 0 element, 1 frame, 2 packet |
| drop_ack | input | NCH | Clears drop bits |
| chan_active | output | NCH | Channel running |
| chan_pending | output | NCH | Single pending request held |
| chan_drop | output | NCH | Sticky event-drop flag |
| chan_sync | output | NCH | Synchronized channel active |
| irq_upd | output | 1 | One-cycle interrupt update pulse |
| busy | output | 1 | Any channel active |

## Verification
Four kinds of behaviour are checked on every cycle. A falling enable always leaves the channel idle with nothing pending. A rising enable always starts a free-running channel. A channel that stays disabled is never active. Each new drop flag is accompanied by an interrupt update pulse, and an acknowledge without a collision clears its flag. The decisions made at boundaries show only in the bench scenarios, because they depend on the pending state, the wait bits and the line levels together: consuming a pending request, staying active on a held line, and matching the granularity pair. The same holds for the single-entry pending rule and the requests that must be ignored.

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
  parameter int NCH   = 16,
  parameter int NLINE = 8,
  localparam int LW = $clog2(NLINE),
  localparam int CW = $clog2(NCH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NCH-1:0]     chan_en,
  input  logic [NCH*LW-1:0]  chan_line,
  input  logic [2*NCH-1:0]   chan_gran,
  input  logic [NCH-1:0]     chan_wait,
  input  logic [NLINE-1:0]   drq,
  input  logic               req_vld,
  input  logic [LW-1:0]      req_line,
  input  logic               bnd_vld,
  input  logic [CW-1:0]      bnd_ch,
  input  logic [1:0]         bnd_kind,
  input  logic [NCH-1:0]     drop_ack,
  output logic [NCH-1:0]     chan_active,
  output logic [NCH-1:0]     chan_pending,
  output logic [NCH-1:0]     chan_drop,
  output logic [NCH-1:0]     chan_sync,
  output logic               irq_upd,
  output logic               busy
);

  logic [NCH-1:0] en_q, act_nx, pend_nx, coll;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [LW-1:0] ln;
    logic [1:0]    gr;
    logic          lvl, synced, kind_ok, hit, rq;
    logic          a, p, c;

    assign ln      = chan_line[i*LW +: LW];
    assign gr      = chan_gran[2*i +: 2];
    assign lvl     = drq[ln];
    assign synced  = (ln != '0);
    assign kind_ok = (gr == 2'b00 && bnd_kind == 2'd0) ||
                     (gr == 2'b10 && bnd_kind == 2'd1) ||
                     (gr == 2'b11 && bnd_kind == 2'd2);
    assign hit     = bnd_vld && (bnd_ch == CW'(i)) && chan_active[i] && synced && kind_ok;
    assign rq      = req_vld && synced && (req_line == ln) && chan_en[i];

    always_comb begin
      a = chan_active[i];
      p = chan_pending[i];
      c = 1'b0;
      if (en_q[i] && !chan_en[i]) begin
        a = 1'b0;
        p = 1'b0;
      end else if (chan_en[i]) begin
        if (!en_q[i]) begin
          a = !synced || lvl;
          p = 1'b0;
        end else if (hit) begin
          if (p && !chan_wait[i]) p = 1'b0;
          else if (!lvl)          a = 1'b0;
        end
        if (rq) begin
          if (!a)      a = 1'b1;
          else if (!p) p = 1'b1;
          else         c = 1'b1;
        end
      end
    end

    assign act_nx[i]    = a;
    assign pend_nx[i]   = p;
    assign coll[i]      = c;
    assign chan_sync[i] = chan_active[i] && synced;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q         <= '0;
      chan_active  <= '0;
      chan_pending <= '0;
      chan_drop    <= '0;
      irq_upd      <= 1'b0;
    end else begin
      en_q         <= chan_en;
      chan_active  <= act_nx;
      chan_pending <= pend_nx;
      chan_drop    <= (chan_drop & ~drop_ack) | coll;
      irq_upd      <= |coll;
    end
  end

  assign busy = |chan_active;

endmodule

// File: rtl/dma_req_sync_chk.sv
module dma_req_sync_chk #(
  parameter int NCH   = 16,
  parameter int NLINE = 8,
  localparam int LW = $clog2(NLINE)
) (
  input logic              clk,
  input logic              rst,
  input logic [NCH-1:0]    chan_en,
  input logic [NCH*LW-1:0] chan_line,
  input logic [NCH-1:0]    drop_ack,
  input logic [NCH-1:0]    chan_active,
  input logic [NCH-1:0]    chan_pending,
  input logic [NCH-1:0]    chan_drop,
  input logic              irq_upd
);
  for (genvar i = 0; i < NCH; i++) begin : g_p
    p_fall_idle_r9: assert property (@(posedge clk) disable iff (rst)
      $fell(chan_en[i]) |=> (!chan_active[i] && !chan_pending[i]));

    p_rise_free_r8: assert property (@(posedge clk) disable iff (rst)
      ($rose(chan_en[i]) && chan_line[i*LW +: LW] == '0) |=> chan_active[i]);

    p_disabled_idle_r12: assert property (@(posedge clk) disable iff (rst)
      $past(!chan_en[i]) |-> !chan_active[i]);

    p_drop_irq_r4: assert property (@(posedge clk) disable iff (rst)
      $rose(chan_drop[i]) |-> irq_upd);

    p_ack_clear_r13: assert property (@(posedge clk) disable iff (rst)
      ($past(chan_drop[i] && drop_ack[i]) && !irq_upd) |-> !chan_drop[i]);
  end
endmodule

bind dma_req_sync dma_req_sync_chk #(.NCH(NCH), .NLINE(NLINE)) u_chk (
  .clk(clk), .rst(rst), .chan_en(chan_en), .chan_line(chan_line),
  .drop_ack(drop_ack), .chan_active(chan_active), .chan_pending(chan_pending),
  .chan_drop(chan_drop), .irq_upd(irq_upd)
);

// File: tb/test_dma_req_sync.sv
module test_dma_req_sync;
  localparam int NCH = 16, NLINE = 8;
  localparam int LW = $clog2(NLINE), CW = $clog2(NCH);

  logic clk = 0, rst = 1;
  logic [NCH-1:0] en = '0, wt = '0, ack = '0;
  logic [NCH*LW-1:0] lines = '0;
  logic [2*NCH-1:0] gran = '0;
  logic [NLINE-1:0] drq = '0;
  logic req_vld = 0, bnd_vld = 0;
  logic [LW-1:0] req_line = '0;
  logic [CW-1:0] bnd_ch = '0;
  logic [1:0] bnd_kind = '0;
  logic [NCH-1:0] act, pend, drop, sy;
  logic irq, busy;

  logic [NCH-1:0] m_act = '0, m_pend = '0, m_drop = '0, m_enq = '0;
  logic m_irq = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dma_req_sync #(.NCH(NCH), .NLINE(NLINE)) i_dma_req_sync (
    .clk(clk), .rst(rst), .chan_en(en), .chan_line(lines), .chan_gran(gran),
    .chan_wait(wt), .drq(drq), .req_vld(req_vld), .req_line(req_line),
    .bnd_vld(bnd_vld), .bnd_ch(bnd_ch), .bnd_kind(bnd_kind), .drop_ack(ack),
    .chan_active(act), .chan_pending(pend), .chan_drop(drop), .chan_sync(sy),
    .irq_upd(irq), .busy(busy));

  function automatic logic [NCH-1:0] exp_sync();
    logic [NCH-1:0] r;
    for (int i = 0; i < NCH; i++) r[i] = m_act[i] && (lines[i*LW +: LW] != '0);
    return r;
  endfunction

  task automatic model_step();
    logic [NCH-1:0] na, np, nd;
    logic ni;
    ni = 0;
    nd = m_drop & ~ack;
    for (int i = 0; i < NCH; i++) begin
      logic [LW-1:0] ln;
      logic [1:0] g;
      logic lvl, syn, a, p, gm;
      ln = lines[i*LW +: LW]; g = gran[2*i +: 2];
      lvl = drq[ln]; syn = (ln != '0);
      a = m_act[i]; p = m_pend[i];
      gm = (g == 2'b00 && bnd_kind == 0) || (g == 2'b10 && bnd_kind == 1) ||
           (g == 2'b11 && bnd_kind == 2);
      if (m_enq[i] && !en[i]) begin a = 0; p = 0; end
      else if (en[i]) begin
        if (!m_enq[i]) begin a = !syn || lvl; p = 0; end
        else if (bnd_vld && int'(bnd_ch) == i && a && syn && gm) begin
          if (p && !wt[i]) p = 0;
          else if (!lvl) a = 0;
        end
        if (req_vld && syn && req_line == ln) begin
          if (!a) a = 1;
          else if (!p) p = 1;
          else begin nd[i] = 1; ni = 1; end
        end
      end
      na[i] = a; np[i] = p;
    end
    if (rst) begin
      m_act = '0; m_pend = '0; m_drop = '0; m_irq = 0; m_enq = '0;
    end else begin
      m_act = na; m_pend = np; m_drop = nd; m_irq = ni; m_enq = en;
    end
  endtask

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic compare(string ph);
    chk({ph, " R7 active"}, 32'(act), 32'(m_act));
    chk({ph, " R3 pending"}, 32'(pend), 32'(m_pend));
    chk({ph, " R4 drop"}, 32'(drop), 32'(m_drop));
    chk({ph, " R4 irq_upd"}, 32'(irq), 32'(m_irq));
    chk({ph, " R10 sync"}, 32'(sy), 32'(exp_sync()));
    chk({ph, " R11 busy"}, 32'(busy), 32'(|m_act));
  endtask

  task automatic step(string ph);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(ph);
    req_vld = 0; bnd_vld = 0; ack = '0;
  endtask

  initial begin
    #3000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    lines[0 +: LW] = 3'd1; gran[1:0] = 2'b00;
    lines[LW +: LW] = 3'd0;
    repeat (2) step("R1");
    rst = 0;
    @(negedge clk);
    chk("R1 reset active", 32'(act), 0);
    chk("R1 reset irq", 32'(irq), 0);

    en[0] = 1; step("R8");
    chk("R8 enable with low line", 32'(act[0]), 0);
    req_vld = 1; req_line = 3'd1; step("R2");
    chk("R2 start", 32'(act[0]), 1);
    req_vld = 1; req_line = 3'd1; step("R3");
    chk("R3 pending", 32'(pend[0]), 1);
    req_vld = 1; req_line = 3'd1; step("R4");
    chk("R4 drop", 32'(drop[0]), 1);
    chk("R4 irq", 32'(irq), 1);
    step("R13");
    chk("R13 sticky", 32'(drop[0]), 1);
    ack[0] = 1; step("R13");
    chk("R13 cleared", 32'(drop[0]), 0);
    bnd_vld = 1; bnd_ch = 0; bnd_kind = 2'd1; step("R7");
    chk("R7 wrong kind ignored", 32'(pend[0]), 1);
    bnd_vld = 1; bnd_kind = 2'd0; step("R5");
    chk("R5 pending used", 32'({act[0], pend[0]}), 32'b10);
    drq[1] = 1; bnd_vld = 1; step("R6");
    chk("R6 held line", 32'(act[0]), 1);
    drq[1] = 0; bnd_vld = 1; step("R7");
    chk("R7 deactivated", 32'(act[0]), 0);
    req_vld = 1; req_line = 3'd0; step("R12");
    chk("R12 line zero", 32'(act), 0);
    en[1] = 1; step("R8");
    chk("R8 free-running", 32'(act[1]), 1);
    chk("R11 busy", 32'(busy), 1);
    en[1] = 0; step("R9");
    chk("R9 disabled", 32'(act[1]), 0);
    en[0] = 0; req_vld = 1; req_line = 3'd1; step("R12");
    chk("R12 disabled channel", 32'({act[0], pend[0]}), 0);

    for (int n = 0; n < 4000; n++) begin
      if (n % 500 == 0)
        for (int i = 0; i < NCH; i++) begin
          lines[i*LW +: LW] = LW'($urandom_range(0, 3));
          gran[2*i +: 2] = 2'($urandom_range(0, 3));
        end
      if ($urandom_range(0, 3) == 0) en[$urandom_range(0, NCH-1)] ^= 1'b1;
      wt = NCH'($urandom) & NCH'($urandom) & NCH'($urandom);
      drq = NLINE'($urandom) & NLINE'($urandom);
      req_vld = $urandom_range(0, 1); req_line = LW'($urandom_range(0, 3));
      bnd_vld = $urandom_range(0, 2) != 0;
      bnd_ch = CW'($urandom_range(0, NCH-1));
      bnd_kind = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 7) == 0) ack = NCH'($urandom);
      if (n == 2000) rst = 1;
      if (n == 2002) rst = 0;
      step("RND");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule